// File: doc/BRIEF.md
# Cache Way Lockdown Controller

This block keeps two per-way lock masks for a set-associative cache. One mask covers the data side and one covers the instruction side. Software reads and writes the masks through a coprocessor register port, which is decoded from an opcode/register field tuple. When a linefill arrives, the block picks a victim way from the mask of the requesting side. It searches round-robin from a per-side pointer and passes over every way whose lock bit is set. If every way on that side is locked, the block raises a no-allocate flag and the fill bypasses the cache.

A mask write must not take effect while linefills are still in flight. While the outstanding fill count is nonzero, a write to either mask is stalled. The requester holds the write on the port until the stall drops. The write then lands on that clock edge, exactly as written. This lets software lock a single way with a simple sequence:

1. Write a mask that leaves only the target way unlocked.
2. Fill the lines it wants kept.
3. Write the final mask with the target way locked and the other bits restored.

Top module: `cache_way_lock`

## Requirements
- R1: After reset both masks read as zero, both round-robin pointers are at way 0, and the first fill on either side gets victim way 0.
- R2: An access is a lockdown access only when op1 = 0, CRn = 9 and CRm = 0. With op2 = 0 it addresses the data mask and with op2 = 1 the instruction mask. A read returns the addressed mask on cp_rdata_o in the same cycle, zero-extended, and reads never stall.
- R3: A valid access with any other field combination raises cp_miss_o in the same cycle and reads zero. A write with such fields leaves both masks unchanged.
- R4: Only bits [NUM_WAYS-1:0] of a mask are stored. The upper write-data bits are dropped and read back as zero.
- R5: A lockdown write while fill_pending_i is nonzero raises cp_stall_o in the same cycle and leaves the mask unchanged. A write with fill_pending_i equal to zero does not stall and lands at the next clock edge.
- R6: victim_way_o is the first way whose lock bit is 0 (lock bit 1 = locked), searching upward with wrap-around from the current pointer of the side given by fill_side_i (0 = data, 1 = instruction).
- R7: When fill_req_i and rr_adv_i are both high and a victim exists, that side's pointer moves to victim+1 modulo NUM_WAYS. Otherwise the pointer holds.
- R8: If all lock bits of the selected side are set, no_alloc_o is 1, victim_way_o is 0 and the pointer does not move.
- R9: Data-side fills use only the data mask and data pointer. Instruction-side fills use only the instruction mask and instruction pointer.
- R10: In the lock-one-way sequence, each mask write takes effect exactly as written. While only way i is unlocked, every fill on that side is given way i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cp_valid_i | input | 1 | Coprocessor access valid |
| cp_write_i | input | 1 | 1 = write, 0 = read |
| cp_op1_i | input | 3 | Opcode 1 field |
| cp_crn_i | input | 4 | Primary register field |
| cp_crm_i | input | 4 | Secondary register field |
| cp_op2_i | input | 3 | Opcode 2 field (0 data, 1 instruction) |
| cp_wdata_i | input | 32 | Write data |
| cp_rdata_o | output | 32 | Read data, zero-extended mask |
| cp_miss_o | output | 1 | Access decoded to no lockdown register |
| cp_stall_o | output | 1 | Lockdown write held off by pending fills |
| fill_req_i | input | 1 | Linefill request |
| fill_side_i | input | 1 | Fill side: 0 data, 1 instruction |
| fill_pending_i | input | 4 | Count of outstanding linefills |
| rr_adv_i | input | 1 | Commit the victim and advance the pointer |
| victim_way_o | output | 2 | Selected victim way |
| no_alloc_o | output | 1 | All ways locked, fill not cached |

## Verification
Read data, the miss flag, the stall flag, the victim way and the no-allocate flag are combinational. Each is due in the same cycle as its stimulus, so the bench drives on the falling edge and samples one nanosecond later. A mask write and a pointer advance become visible only after the next rising edge. The bench model therefore applies them after that edge, and the following step checks their effect through a read or a fill. Stalled writes are checked by reading the mask back in the next step and finding it unchanged.

// File: rtl/cwl_pkg.sv
package cwl_pkg;
  localparam int NUM_WAYS_DEF = 4;
  localparam int DATA_W_DEF   = 32;
  localparam int CNT_W_DEF    = 4;

  localparam logic [2:0] LOCK_OP1   = 3'd0;
  localparam logic [3:0] LOCK_CRN   = 4'd9;
  localparam logic [3:0] LOCK_CRM   = 4'd0;
  localparam logic [2:0] OP2_DATA   = 3'd0;
  localparam logic [2:0] OP2_INSTR  = 3'd1;

  typedef enum logic {
    SIDE_DATA  = 1'b0,
    SIDE_INSTR = 1'b1
  } side_e;
endpackage

// File: rtl/cwl_cp_decode.sv
module cwl_cp_decode
  import cwl_pkg::*;
(
  input  logic       valid_i,
  input  logic [2:0] op1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] op2_i,
  output logic [1:0] sel_o,
  output logic       miss_o
);
  logic reg_hit;

  assign reg_hit = valid_i && (op1_i == LOCK_OP1) && (crn_i == LOCK_CRN)
                   && (crm_i == LOCK_CRM);

  always_comb begin
    sel_o = '0;
    sel_o[SIDE_DATA]  = reg_hit && (op2_i == OP2_DATA);
    sel_o[SIDE_INSTR] = reg_hit && (op2_i == OP2_INSTR);
  end

  assign miss_o = valid_i && (sel_o == '0);
endmodule

// File: rtl/cwl_mask_reg.sv
module cwl_mask_reg #(
  parameter int NUM_WAYS = 4,
  parameter int DATA_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                hold_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [NUM_WAYS-1:0] mask_o
);
  logic [NUM_WAYS-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 mask_q <= '0;
    else if (wr_en_i && !hold_i) mask_q <= wdata_i[NUM_WAYS-1:0];
  end

  assign mask_o = mask_q;

  AST_HOLD_WHILE_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hold_i) |=> $stable(mask_q)); // R5
  AST_WRITE_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hold_i) |=> (mask_q == $past(wdata_i[NUM_WAYS-1:0]))); // R10
endmodule

// File: rtl/cwl_victim_sel.sv
module cwl_victim_sel #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_WAYS-1:0] mask_i,
  input  logic                commit_i,
  output logic [WAY_W-1:0]    victim_o,
  output logic                none_o
);
  logic [WAY_W-1:0] ptr_q;
  logic [WAY_W-1:0] ptr_next;
  logic [WAY_W-1:0] idx;

  // Downward scan so the nearest unlocked way from ptr_q wins.
  always_comb begin
    victim_o = '0;
    none_o   = 1'b1;
    idx      = '0;
    for (int j = NUM_WAYS - 1; j >= 0; j--) begin
      idx = WAY_W'((int'(ptr_q) + j) % NUM_WAYS);
      if (!mask_i[idx]) begin
        victim_o = idx;
        none_o   = 1'b0;
      end
    end
  end

  assign ptr_next = (int'(victim_o) == NUM_WAYS - 1) ? '0 : victim_o + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ptr_q <= '0;
    else if (commit_i && !none_o) ptr_q <= ptr_next;
  end

  AST_VICTIM_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !none_o |-> !mask_i[victim_o]); // R6
  AST_NONE_ALL_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    none_o |-> (&mask_i && victim_o == '0)); // R8
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i || none_o) |=> $stable(ptr_q)); // R7
endmodule

// File: rtl/cache_way_lock.sv
module cache_way_lock
  import cwl_pkg::*;
#(
  parameter int NUM_WAYS = NUM_WAYS_DEF,
  parameter int DATA_W   = DATA_W_DEF,
  parameter int CNT_W    = CNT_W_DEF,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cp_valid_i,
  input  logic              cp_write_i,
  input  logic [2:0]        cp_op1_i,
  input  logic [3:0]        cp_crn_i,
  input  logic [3:0]        cp_crm_i,
  input  logic [2:0]        cp_op2_i,
  input  logic [DATA_W-1:0] cp_wdata_i,
  output logic [DATA_W-1:0] cp_rdata_o,
  output logic              cp_miss_o,
  output logic              cp_stall_o,
  input  logic              fill_req_i,
  input  logic              fill_side_i,
  input  logic [CNT_W-1:0]  fill_pending_i,
  input  logic              rr_adv_i,
  output logic [WAY_W-1:0]  victim_way_o,
  output logic              no_alloc_o
);
  localparam int NUM_SIDES = 2;

  logic [NUM_SIDES-1:0]               sel;
  logic                               fills_busy;
  logic [NUM_SIDES-1:0][NUM_WAYS-1:0] mask;
  logic [NUM_SIDES-1:0][WAY_W-1:0]    vict;
  logic [NUM_SIDES-1:0]               none;

  cwl_cp_decode u_dec (
    .valid_i (cp_valid_i),
    .op1_i   (cp_op1_i),
    .crn_i   (cp_crn_i),
    .crm_i   (cp_crm_i),
    .op2_i   (cp_op2_i),
    .sel_o   (sel),
    .miss_o  (cp_miss_o)
  );

  assign fills_busy = (fill_pending_i != '0);
  assign cp_stall_o = cp_write_i && (sel != '0) && fills_busy;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    cwl_mask_reg #(
      .NUM_WAYS (NUM_WAYS),
      .DATA_W   (DATA_W)
    ) u_mask (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (cp_write_i && sel[s]),
      .hold_i  (fills_busy),
      .wdata_i (cp_wdata_i),
      .mask_o  (mask[s])
    );

    cwl_victim_sel #(
      .NUM_WAYS (NUM_WAYS)
    ) u_vsel (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mask_i   (mask[s]),
      .commit_i (fill_req_i && rr_adv_i && (fill_side_i == 1'(s))),
      .victim_o (vict[s]),
      .none_o   (none[s])
    );
  end

  always_comb begin
    cp_rdata_o = '0;
    if (sel[SIDE_DATA])       cp_rdata_o = {{(DATA_W-NUM_WAYS){1'b0}}, mask[SIDE_DATA]};
    else if (sel[SIDE_INSTR]) cp_rdata_o = {{(DATA_W-NUM_WAYS){1'b0}}, mask[SIDE_INSTR]};
  end

  assign victim_way_o = vict[fill_side_i];
  assign no_alloc_o   = none[fill_side_i];

  AST_MISS_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_miss_o |-> (cp_rdata_o == '0 && !cp_stall_o)); // R3
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_rdata_o >> NUM_WAYS) == '0); // R4
endmodule

// File: tb/cache_way_lock_tb.sv
module cache_way_lock_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cp_valid_i = 0, cp_write_i = 0;
  logic [2:0]  cp_op1_i = 0, cp_op2_i = 0;
  logic [3:0]  cp_crn_i = 0, cp_crm_i = 0;
  logic [31:0] cp_wdata_i = 0;
  logic [31:0] cp_rdata_o;
  logic        cp_miss_o, cp_stall_o;
  logic        fill_req_i = 0, fill_side_i = 0, rr_adv_i = 0;
  logic [3:0]  fill_pending_i = 0;
  logic [1:0]  victim_way_o;
  logic        no_alloc_o;

  int checks = 0;
  int errors = 0;
  logic [3:0] m_mask [2];
  logic [1:0] m_ptr  [2];

  always #2 clk_i = ~clk_i;

  cache_way_lock u_dut (.*);

  function automatic logic [2:0] exp_victim(input logic [3:0] m, input logic [1:0] p);
    for (int j = 0; j < 4; j++) begin
      logic [1:0] w;
      w = p + 2'(j);
      if (!m[w]) return {1'b0, w};
    end
    return 3'b100;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic wr,
                      input logic [2:0] o1, input logic [3:0] rn, input logic [3:0] rm,
                      input logic [2:0] o2, input logic [31:0] wd, input logic [3:0] pend,
                      input logic fr, input logic fs, input logic adv);
    logic hit, side, none;
    logic [2:0] ev;
    @(negedge clk_i);
    cp_valid_i = v; cp_write_i = wr; cp_op1_i = o1; cp_crn_i = rn; cp_crm_i = rm;
    cp_op2_i = o2; cp_wdata_i = wd; fill_pending_i = pend;
    fill_req_i = fr; fill_side_i = fs; rr_adv_i = adv;
    #1;
    hit  = v && o1 == 3'd0 && rn == 4'd9 && rm == 4'd0 && (o2 == 3'd0 || o2 == 3'd1);
    side = o2[0];
    ev   = exp_victim(m_mask[fs], m_ptr[fs]);
    none = ev[2];
    check({tag, " R2 rdata"}, cp_rdata_o, hit ? {28'b0, m_mask[side]} : 32'b0);
    check({tag, " R3 miss"}, 32'(cp_miss_o), 32'(v && !hit));
    check({tag, " R5 stall"}, 32'(cp_stall_o), 32'(hit && wr && pend != 0));
    check({tag, " R6 victim"}, 32'(victim_way_o), 32'(ev[1:0]));
    check({tag, " R8 no_alloc"}, 32'(no_alloc_o), 32'(none));
    @(posedge clk_i);
    if (hit && wr && pend == 0) m_mask[side] = wd[3:0];
    if (fr && adv && !none) m_ptr[fs] = ev[1:0] + 2'd1;
  endtask

  task automatic rd(input string tag, input logic s);
    step(tag, 1, 0, 0, 9, 0, {2'b0, s}, 0, 0, 0, 0, 0);
  endtask
  task automatic wr(input string tag, input logic s, input logic [31:0] d, input logic [3:0] pend);
    step(tag, 1, 1, 0, 9, 0, {2'b0, s}, d, pend, 0, 0, 0);
  endtask
  task automatic fill(input string tag, input logic s, input logic adv);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 1, s, adv);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    m_mask[0] = 0; m_mask[1] = 0; m_ptr[0] = 0; m_ptr[1] = 0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    rd("R1", 0); rd("R1", 1);
    @(negedge clk_i); fill_req_i = 1; fill_side_i = 0; #1;
    check("R1 victim data", 32'(victim_way_o), 0);
    fill_side_i = 1; #1;
    check("R1 victim instr", 32'(victim_way_o), 0);
    fill_req_i = 0;

    // R4 upper bits dropped
    wr("R4", 0, 32'hFFFF_FFF5, 0); rd("R4", 0);
    @(negedge clk_i); cp_valid_i = 1; cp_write_i = 0; cp_op1_i = 0; cp_crn_i = 9;
    cp_crm_i = 0; cp_op2_i = 0; #1;
    check("R4 readback", cp_rdata_o, 32'h5);

    // R3 bad encodings write nothing
    step("R3", 1, 1, 3'd1, 9, 0, 0, 32'hA, 0, 0, 0, 0);
    step("R3", 1, 1, 0, 9, 1, 1, 32'hA, 0, 0, 0, 0);
    step("R3", 1, 1, 0, 9, 0, 3'd2, 32'hA, 0, 0, 0, 0);
    rd("R3", 0); rd("R3", 1);

    // R5 stall while fills pending, then land
    wr("R5", 1, 32'h3, 4'd2); rd("R5", 1);
    wr("R5", 1, 32'h3, 4'd0); rd("R5", 1);

    // R7 / R9 round-robin on both sides independently
    wr("R9", 0, 32'h0, 0); wr("R9", 1, 32'h0, 0);
    fill("R7", 0, 1); fill("R7", 0, 1); fill("R7", 0, 0); fill("R9", 1, 1);
    fill("R9", 0, 1); fill("R9", 1, 1);

    // R8 all locked, pointer stays
    wr("R8", 0, 32'hF, 0); fill("R8", 0, 1); fill("R8", 0, 1);
    wr("R8", 0, 32'h0, 0); fill("R8", 0, 0);

    // R10 lock way 2 on data side
    wr("R10", 0, 32'h1, 0);
    wr("R10", 0, 32'hB, 0);
    fill("R10", 0, 1); fill("R10", 0, 1); fill("R10", 0, 1);
    wr("R10", 0, 32'h5, 0); rd("R10", 0); fill("R10", 0, 1);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] d;
      logic [3:0] pend;
      int k;
      k = $urandom_range(0, 3);
      d = (k == 0) ? 32'hF : (k == 1) ? ~(32'h1 << $urandom_range(0, 3)) : $urandom;
      pend = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(1, 15)) : 4'd0;
      case ($urandom_range(0, 4))
        0: wr("RND", 1'($urandom_range(0, 1)), d, pend);
        1: rd("RND", 1'($urandom_range(0, 1)));
        2: step("RND", 1, 1'($urandom_range(0, 1)), 3'($urandom), 4'($urandom),
                4'($urandom), 3'($urandom), d, pend, 0, 0, 0);
        default: fill("RND", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0));
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule